// File: doc/BRIEF.md
# Serial Link Power State Controller

This controller sequences one serial link through three power levels: fully active, a light sleep that powers down only the data lanes and their drivers, and a deep sleep that powers down all link circuitry. It drives two enable outputs, one for the lane drivers and one for the rest of the link logic. It also drives a state code and a link-ready flag that tells the traffic source when it may send.

Sleep requests come in on two inputs, one for each level. A single wake input signals pending traffic or an explicit wake. Leaving either sleep level passes through a waking state whose length is a parameter, and the deep level takes longer. While waking, the core logic is enabled first. The lane drivers follow halfway through the wake window, and link-ready rises only when the window has fully elapsed.

Top module: `link_pm_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `pwr_state` is 0, and `lane_en`, `core_en` and `link_ready` are all 1.
- R2: `pwr_state` encodes 0 = active, 1 = light sleep, 2 = deep sleep, 3 = waking.
- R3: In the active state with `wake_req` low, `sleep_deep` moves the state to deep sleep on the next edge. `sleep_light` alone moves it to light sleep. When both are high, deep sleep wins.
- R4: In the active state with `wake_req` high, both sleep requests are ignored and the state stays active.
- R5: In light sleep, `lane_en` is 0, `core_en` is 1 and `link_ready` is 0.
- R6: In deep sleep, `lane_en`, `core_en` and `link_ready` are all 0.
- R7: In light sleep, `sleep_light` is ignored. `sleep_deep` with `wake_req` low moves to deep sleep. `wake_req` starts waking and has priority over `sleep_deep`.
- R8: In deep sleep, both sleep requests are ignored. Only `wake_req` leaves, into the waking state.
- R9: Count the edge that captures `wake_req` in a sleep state as edge 0. The state returns to active, and `link_ready` rises, on edge N. N is LIGHT_WAKE when waking from light sleep and DEEP_WAKE when waking from deep sleep.
- R10: During waking, `core_en` is 1 from edge 0 on. `lane_en` is 0 before edge N/2 and 1 from edge N/2 on.
- R11: During waking, `sleep_light`, `sleep_deep` and `wake_req` have no effect on the state, the enables or the timing.
- R12: `link_ready` is 1 exactly when `pwr_state` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_light | input | 1 | Request to enter light sleep |
| sleep_deep | input | 1 | Request to enter deep sleep |
| wake_req | input | 1 | Traffic pending or wake request |
| lane_en | output | 1 | Enable for data lanes and their drivers |
| core_en | output | 1 | Enable for the remaining link circuitry |
| pwr_state | output | 2 | Current power state code |
| link_ready | output | 1 | Link may accept traffic |

## Verification
The bench builds the controller with its default wake lengths of 8 and 64 cycles. With these, the two exit paths differ by a factor of eight, and the lane-restore point lands mid-window at distinct edges (4 and 32). A latency or ordering swap between the two levels therefore shows up at an exact edge. The deep wake stays short enough to be walked edge by edge, including once with every request input held high to probe the ignore rule.

// File: rtl/link_pm_pkg.sv
package link_pm_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_LIGHT  = 2'd1,
    PM_DEEP   = 2'd2,
    PM_WAKING = 2'd3
  } pm_state_e;

  // Length of the wake window for the level being left.
  function automatic logic [31:0] wake_span(input logic from_deep,
                                            input logic [31:0] light_len,
                                            input logic [31:0] deep_len);
    return from_deep ? deep_len : light_len;
  endfunction

  // Lanes come back once the remaining count drops below half the window.
  function automatic logic lanes_back(input logic [31:0] remaining,
                                      input logic [31:0] span);
    return remaining < (span >> 1);
  endfunction
endpackage

// File: rtl/pm_req_arbiter.sv
module pm_req_arbiter
  import link_pm_pkg::*;
(
  input  pm_state_e state,
  input  logic      sleep_light,
  input  logic      sleep_deep,
  input  logic      wake_req,
  input  logic      timer_done,
  output pm_state_e state_nx,
  output logic      load_wake,
  output logic      wake_deep
);
  always_comb begin
    state_nx  = state;
    load_wake = 1'b0;
    wake_deep = 1'b0;
    unique case (state)
      PM_ACTIVE: begin
        if (!wake_req) begin
          if (sleep_deep)       state_nx = PM_DEEP;
          else if (sleep_light) state_nx = PM_LIGHT;
        end
      end
      PM_LIGHT: begin
        if (wake_req) begin
          state_nx  = PM_WAKING;
          load_wake = 1'b1;
        end else if (sleep_deep) begin
          state_nx = PM_DEEP;
        end
      end
      PM_DEEP: begin
        if (wake_req) begin
          state_nx  = PM_WAKING;
          load_wake = 1'b1;
          wake_deep = 1'b1;
        end
      end
      PM_WAKING: begin
        if (timer_done) state_nx = PM_ACTIVE;
      end
      default: state_nx = PM_ACTIVE;
    endcase
  end
endmodule

// File: rtl/pm_wake_timer.sv
module pm_wake_timer #(
  parameter int unsigned LIGHT_WAKE = 8,
  parameter int unsigned DEEP_WAKE  = 64,
  parameter int unsigned CW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          from_deep,
  input  logic          run,
  output logic [CW-1:0] cnt,
  output logic          deep_q,
  output logic          done
);
  localparam logic [CW-1:0] LIGHT_LOAD = CW'(LIGHT_WAKE - 1);
  localparam logic [CW-1:0] DEEP_LOAD  = CW'(DEEP_WAKE - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      deep_q <= 1'b0;
    end else if (load) begin
      cnt    <= from_deep ? DEEP_LOAD : LIGHT_LOAD;
      deep_q <= from_deep;
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = run && (cnt == '0);
endmodule

// File: rtl/pm_enable_map.sv
module pm_enable_map
  import link_pm_pkg::*;
#(
  parameter int unsigned LIGHT_WAKE = 8,
  parameter int unsigned DEEP_WAKE  = 64,
  parameter int unsigned CW         = 6
) (
  input  pm_state_e     state,
  input  logic [CW-1:0] cnt,
  input  logic          deep_q,
  output logic          lane_en,
  output logic          core_en,
  output logic          ready
);
  logic [31:0] span;
  assign span = wake_span(deep_q, 32'(LIGHT_WAKE), 32'(DEEP_WAKE));

  always_comb begin
    lane_en = 1'b0;
    core_en = 1'b0;
    ready   = 1'b0;
    unique case (state)
      PM_ACTIVE: begin
        lane_en = 1'b1;
        core_en = 1'b1;
        ready   = 1'b1;
      end
      PM_LIGHT:  core_en = 1'b1;
      PM_DEEP:   core_en = 1'b0;
      PM_WAKING: begin
        core_en = 1'b1;
        lane_en = lanes_back(32'(cnt), span);
      end
      default: core_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/link_pm_ctrl.sv
module link_pm_ctrl
  import link_pm_pkg::*;
#(
  parameter int unsigned LIGHT_WAKE = 8,
  parameter int unsigned DEEP_WAKE  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_light,
  input  logic       sleep_deep,
  input  logic       wake_req,
  output logic       lane_en,
  output logic       core_en,
  output logic [1:0] pwr_state,
  output logic       link_ready
);
  localparam int unsigned CW = (DEEP_WAKE > 2) ? $clog2(DEEP_WAKE) : 1;

  pm_state_e     state_q;
  pm_state_e     state_nx;
  logic          load_wake;
  logic          wake_deep;
  logic          timer_done;
  logic          timer_run;
  logic [CW-1:0] wake_cnt;
  logic          wake_deep_q;

  assign timer_run = (state_q == PM_WAKING);

  pm_req_arbiter u_arb (
    .state       (state_q),
    .sleep_light (sleep_light),
    .sleep_deep  (sleep_deep),
    .wake_req    (wake_req),
    .timer_done  (timer_done),
    .state_nx    (state_nx),
    .load_wake   (load_wake),
    .wake_deep   (wake_deep)
  );

  pm_wake_timer #(.LIGHT_WAKE(LIGHT_WAKE), .DEEP_WAKE(DEEP_WAKE), .CW(CW)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_wake),
    .from_deep (wake_deep),
    .run       (timer_run),
    .cnt       (wake_cnt),
    .deep_q    (wake_deep_q),
    .done      (timer_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_ACTIVE;
    else        state_q <= state_nx;
  end

  pm_enable_map #(.LIGHT_WAKE(LIGHT_WAKE), .DEEP_WAKE(DEEP_WAKE), .CW(CW)) u_map (
    .state   (state_q),
    .cnt     (wake_cnt),
    .deep_q  (wake_deep_q),
    .lane_en (lane_en),
    .core_en (core_en),
    .ready   (link_ready)
  );

  assign pwr_state = state_q;
endmodule

// File: rtl/link_pm_ctrl_chk.sv
module link_pm_ctrl_chk #(
  parameter int unsigned LIGHT_WAKE = 8,
  parameter int unsigned DEEP_WAKE  = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_light,
  input logic       sleep_deep,
  input logic       wake_req,
  input logic       lane_en,
  input logic       core_en,
  input logic [1:0] pwr_state,
  input logic       link_ready,
  input logic       load_wake,
  input logic       wake_deep
);
  localparam int unsigned KW = $clog2(DEEP_WAKE + 1);

  logic [KW-1:0] seen_cyc;
  logic [KW-1:0] want_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_cyc <= '0;
      want_cyc <= '0;
    end else begin
      if (pwr_state == 2'd3) seen_cyc <= seen_cyc + 1'b1;
      else                   seen_cyc <= '0;
      if (load_wake) want_cyc <= wake_deep ? KW'(DEEP_WAKE) : KW'(LIGHT_WAKE);
    end
  end

  assert_light_lanes_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'd1 |-> !lane_en && core_en && !link_ready);

  assert_deep_all_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'd2 |-> !lane_en && !core_en && !link_ready);

  assert_ready_means_active_R12: assert property (@(posedge clk) disable iff (!rst_n)
    link_ready == (pwr_state == 2'd0));

  assert_wake_blocks_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'd0 && wake_req |=> pwr_state == 2'd0);

  assert_light_from_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'd1 && $past(pwr_state) != 2'd1 |-> $past(pwr_state) == 2'd0);

  assert_lanes_after_core_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_en) |-> core_en && $past(core_en));

  assert_ready_after_lanes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready) |-> $past(lane_en));

  assert_wake_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'd0 && $past(pwr_state) == 2'd3 |-> seen_cyc == want_cyc);

  assert_deep_exit_only_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'd2 && !wake_req |=> pwr_state == 2'd2);

  logic unused_in;
  assign unused_in = sleep_light ^ sleep_deep;
endmodule

bind link_pm_ctrl link_pm_ctrl_chk #(.LIGHT_WAKE(LIGHT_WAKE), .DEEP_WAKE(DEEP_WAKE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_light (sleep_light),
  .sleep_deep  (sleep_deep),
  .wake_req    (wake_req),
  .lane_en     (lane_en),
  .core_en     (core_en),
  .pwr_state   (pwr_state),
  .link_ready  (link_ready),
  .load_wake   (load_wake),
  .wake_deep   (wake_deep)
);

// File: tb/tb_link_pm_ctrl.sv
`timescale 1ns/1ps
module tb_link_pm_ctrl;
  localparam int LW = 8;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_light = 1'b0, sleep_deep = 1'b0, wake_req = 1'b0;
  logic lane_en, core_en, link_ready;
  logic [1:0] pwr_state;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  link_pm_ctrl #(.LIGHT_WAKE(LW), .DEEP_WAKE(DW)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_light(sleep_light), .sleep_deep(sleep_deep),
    .wake_req(wake_req), .lane_en(lane_en), .core_en(core_en),
    .pwr_state(pwr_state), .link_ready(link_ready)
  );

  // {light, deep, wake, exp_state[1:0], exp_lane, exp_core, exp_ready}
  localparam logic [7:0] VEC [0:6] = '{
    {3'b111, 2'd0, 3'b111},  // R4 wake blocks sleep
    {3'b100, 2'd1, 3'b010},  // R3 light entry, R5
    {3'b100, 2'd1, 3'b010},  // R7 light request ignored in light
    {3'b010, 2'd2, 3'b000},  // R7 light to deep, R6
    {3'b110, 2'd2, 3'b000},  // R8 requests ignored in deep
    {3'b000, 2'd2, 3'b000},  // R6 deep holds
    {3'b001, 2'd3, 3'b010}   // R8 wake leaves deep, R10 core first
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R4";
      1: return "R3";
      2: return "R7";
      3: return "R7";
      4: return "R8";
      5: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(string tag, int st, int ln, int cr, int rd);
    chk({tag, " state"}, pwr_state, st);
    chk({tag, " lane_en"}, lane_en, ln);
    chk({tag, " core_en"}, core_en, cr);
    chk({tag, " link_ready"}, link_ready, rd);
    chk("R12 ready iff active", link_ready, (pwr_state == 2'd0) ? 1 : 0);
  endtask

  task automatic step(logic l, logic d, logic w);
    sleep_light = l; sleep_deep = d; wake_req = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Edges 1..len after the capture edge; noisy holds every input high.
  task automatic walk_wake(int len, bit noisy, string tag);
    for (int j = 1; j <= len; j++) begin
      step(noisy, noisy, noisy);
      chk_all(tag, (j < len) ? 3 : 0, (j >= len / 2) ? 1 : 0, 1, (j >= len) ? 1 : 0);
    end
    step(0, 0, 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk_all("R1 in reset", 0, 1, 1, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after reset", 0, 1, 1, 1);

    for (int i = 0; i < 7; i++) begin
      step(VEC[i][7], VEC[i][6], VEC[i][5]);
      chk_all(vec_tag(i), int'(VEC[i][4:3]), int'(VEC[i][2]), int'(VEC[i][1]), int'(VEC[i][0]));
    end
    walk_wake(DW, 1'b0, "R9 R10 deep wake");

    // R3: both requests in active pick deep sleep
    step(1, 1, 0);
    chk_all("R3 both picks deep", 2, 0, 0, 0);
    // R7-style priority in deep: wake with requests -> waking; R11 noisy wake
    step(1, 1, 1);
    chk_all("R8 wake from deep", 3, 0, 1, 0);
    walk_wake(DW, 1'b1, "R11 noisy deep wake");

    // R7: light sleep, then wake together with deep request
    step(1, 0, 0);
    chk_all("R3 light entry", 1, 0, 1, 0);
    step(0, 1, 1);
    chk_all("R7 wake beats deep", 3, 0, 1, 0);
    walk_wake(LW, 1'b0, "R9 R10 light wake");

    // R11 during light wake
    step(1, 0, 0);
    step(0, 0, 1);
    chk_all("R7 wake from light", 3, 0, 1, 0);
    walk_wake(LW, 1'b1, "R11 noisy light wake");

    // R2 encoding seen across states, R1 reset mid-wake
    step(0, 1, 0);
    chk("R2 deep code", pwr_state, 2);
    step(0, 0, 1);
    step(0, 0, 0);
    rst_n = 1'b0;
    #1;
    chk_all("R1 reset mid-wake", 0, 1, 1, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after mid-wake reset", 0, 1, 1, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule